// File: doc/BRIEF.md
# Flash Busy-Status Read Generator

This block sits in the read data path of a byte-wide flash array. While an internal program or erase operation runs, the host cannot read the array. Instead, each host read returns a status byte from which the host can tell when the operation has ended. Two signals are carried in that byte. The polling bit is the inverse of the most significant bit of the byte being programmed. The toggle bit flips on every successive read access during the busy period. When the operation has finished, reads return the true array data again, so the polling bit shows the programmed value and the toggle bit stops changing.

A read access is the clock edge at which chip select and output enable are both seen high after they were not both high at the previous edge. On that edge the output register captures either the status byte or the array data, and it holds that value until the next access. A pulse on `op_start` marks the beginning of a new operation and clears the toggle state. The host can begin polling at any read within the busy period; no setup sequence is needed.

Top module: `flash_busy_status_rd`

## Requirements
- R1: After reset, `rd_data` is 0 and the first busy read returns toggle bit 0.
- R2: A read access happens only at a clock edge where `host_sel` and `host_oe` are both 1 and were not both 1 at the previous edge. Holding them high for several cycles counts as one access.
- R3: On a busy read of a program operation (`op_erase`=0), bit 7 of `rd_data` is the inverse of bit 7 of `prog_byte`.
- R4: On a busy read of an erase operation (`op_erase`=1), bit 7 of `rd_data` is 0.
- R5: On busy reads, bit 6 of `rd_data` alternates 0, 1, 0, ... across successive read accesses, starting at 0 after `op_start`.
- R6: On busy reads, bits 5 to 0 of `rd_data` are 0.
- R7: On a read access with `op_busy`=0, `rd_data` equals `array_rdata` on all bits, and the toggle state does not change.
- R8: Between read accesses, `rd_data` holds its last captured value.
- R9: `op_start` clears the toggle state. A busy read in the same cycle as `op_start` returns bit 6 = 0, and the next busy read returns 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_start | input | 1 | One-cycle pulse at the start of a program or erase operation |
| op_busy | input | 1 | High while the internal operation runs |
| op_erase | input | 1 | 1 = current operation is an erase, 0 = program |
| prog_byte | input | 8 | Last byte loaded for programming |
| array_rdata | input | 8 | Normal array read data |
| host_sel | input | 1 | Host chip select, active high |
| host_oe | input | 1 | Host output enable, active high |
| rd_data | output | 8 | Byte returned to the host, updated on each read access |

## Verification
A toggle register stuck at one value, or one that flips on idle cycles, shows up at the next busy read as a repeated or skipped bit 6. The error is therefore visible one clock after the second read access. A faulty strobe edge detector makes a held strobe look like several accesses, so the toggle phase of the following read comes out wrong. A wrong polling source or a wrong busy/idle selection corrupts `rd_data` in the cycle right after the access. The bench compares `rd_data` against a behavioural model on every clock, which catches each of these faults within one read.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

  // Status carried in a busy read: polling and toggle bits.
  typedef struct packed {
    logic poll;
    logic tgl;
  } busy_stat_t;

  // Polling value: an erase reads 0 (inverse of erased 1s), a program
  // reads the inverse of the loaded byte's top bit.
  function automatic logic poll_value(input logic is_erase, input logic prog_msb);
    return is_erase ? 1'b0 : ~prog_msb;
  endfunction

  function automatic busy_stat_t make_status(input logic is_erase,
                                             input logic prog_msb,
                                             input logic tgl_now);
    busy_stat_t s;
    s.poll = poll_value(is_erase, prog_msb);
    s.tgl  = tgl_now;
    return s;
  endfunction

endpackage

// File: rtl/fsr_strobe_edge.sv
module fsr_strobe_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sel,
  input  logic oe,
  output logic rd_evt
);
  logic strobe;
  logic strobe_q;

  assign strobe = sel & oe;

  always_ff @(posedge clk) begin
    if (!rst_n) strobe_q <= 1'b0;
    else        strobe_q <= strobe;
  end

  assign rd_evt = strobe & ~strobe_q;

  // R2: an access is a single-cycle event
  a_r2_single_event: assert property (@(posedge clk) disable iff (!rst_n)
    rd_evt |=> !rd_evt);
  // R2: strobe held high yields no further events
  a_r2_held_no_event: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && oe) |=> !(sel && oe) || !rd_evt);
endmodule

// File: rtl/fsr_toggle_track.sv
module fsr_toggle_track (
  input  logic clk,
  input  logic rst_n,
  input  logic op_start,
  input  logic busy_rd,
  output logic tgl_use
);
  logic tgl_q;

  // value seen by a read in this cycle: cleared by a coincident start
  assign tgl_use = op_start ? 1'b0 : tgl_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       tgl_q <= 1'b0;
    else if (busy_rd) tgl_q <= ~tgl_use;
    else              tgl_q <= tgl_use;
  end

  // R5: each busy read flips the stored toggle
  a_r5_flip_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_rd && !op_start) |=> tgl_q != $past(tgl_q));
  // R7: no busy read, no start: toggle stays
  a_r7_toggle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_rd && !op_start) |=> $stable(tgl_q));
  // R9: start without a read clears the toggle
  a_r9_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (op_start && !busy_rd) |=> !tgl_q);
  // R9: start with a read leaves the toggle at 1
  a_r9_start_read: assert property (@(posedge clk) disable iff (!rst_n)
    (op_start && busy_rd) |=> tgl_q);
endmodule

// File: rtl/fsr_data_sel.sv
module fsr_data_sel #(
  parameter int DATA_W     = 8,
  parameter int POLL_BIT   = 7,
  parameter int TOGGLE_BIT = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_evt,
  input  logic              busy,
  input  logic              poll,
  input  logic              tgl,
  input  logic [DATA_W-1:0] array_rdata,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] status_vec;

  generate
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      if (i == POLL_BIT) begin : g_poll
        assign status_vec[i] = poll;
      end else if (i == TOGGLE_BIT) begin : g_tgl
        assign status_vec[i] = tgl;
      end else begin : g_zero
        assign status_vec[i] = 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)      rd_data <= '0;
    else if (rd_evt) rd_data <= busy ? status_vec : array_rdata;
  end

  // R7: idle read returns true array data
  a_r7_true_data: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_evt && !busy) |=> rd_data == $past(array_rdata));
  // R8: output holds between accesses
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_evt |=> $stable(rd_data));
  // R6: non-status bits clear on busy reads
  a_r6_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_evt && busy) |=> $countones(rd_data) <= 2);
endmodule

// File: rtl/flash_busy_status_rd.sv
module flash_busy_status_rd #(
  parameter int DATA_W     = 8,
  parameter int POLL_BIT   = 7,
  parameter int TOGGLE_BIT = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_start,
  input  logic              op_busy,
  input  logic              op_erase,
  input  logic [DATA_W-1:0] prog_byte,
  input  logic [DATA_W-1:0] array_rdata,
  input  logic              host_sel,
  input  logic              host_oe,
  output logic [DATA_W-1:0] rd_data
);
  import fsr_pkg::*;

  localparam int MSB = DATA_W - 1;

  // named internal events for the assertions
  logic       rd_evt;
  logic       busy_rd;
  logic       tgl_use;
  busy_stat_t stat;

  fsr_strobe_edge u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .sel   (host_sel),
    .oe    (host_oe),
    .rd_evt(rd_evt)
  );

  assign busy_rd = rd_evt & op_busy;

  fsr_toggle_track u_tgl (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_start(op_start),
    .busy_rd (busy_rd),
    .tgl_use (tgl_use)
  );

  assign stat = make_status(op_erase, prog_byte[MSB], tgl_use);

  fsr_data_sel #(
    .DATA_W    (DATA_W),
    .POLL_BIT  (POLL_BIT),
    .TOGGLE_BIT(TOGGLE_BIT)
  ) u_sel (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_evt     (rd_evt),
    .busy       (op_busy),
    .poll       (stat.poll),
    .tgl        (stat.tgl),
    .array_rdata(array_rdata),
    .rd_data    (rd_data)
  );

  // R3: program polling bit is the inverse of the loaded top bit
  a_r3_poll_program: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_rd && !op_erase) |=> rd_data[POLL_BIT] == !$past(prog_byte[MSB]));
  // R4: erase polling bit reads 0
  a_r4_poll_erase: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_rd && op_erase) |=> !rd_data[POLL_BIT]);
  // R9: read coincident with start shows toggle 0
  a_r9_first_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_rd && op_start) |=> !rd_data[TOGGLE_BIT]);
  // R1: output is clear right after reset
  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> rd_data == '0);
endmodule

// File: tb/flash_busy_status_rd_test.sv
module flash_busy_status_rd_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 0;
  logic rst_n = 0;
  logic op_start = 0, op_busy = 0, op_erase = 0;
  logic [7:0] prog_byte = 0, array_rdata = 0;
  logic host_sel = 0, host_oe = 0;
  logic [7:0] rd_data;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_busy_status_rd uut (
    .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_busy(op_busy),
    .op_erase(op_erase), .prog_byte(prog_byte), .array_rdata(array_rdata),
    .host_sel(host_sel), .host_oe(host_oe), .rd_data(rd_data)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model, updated each clock
  int  m_prev, m_tgl, m_data;
  string m_tag = "R1";
  always @(posedge clk) begin
    if (!rst_n) begin
      m_prev = 0; m_tgl = 0; m_data = 0; m_tag = "R1";
    end else begin
      int strobe, evt, base;
      strobe = (host_sel && host_oe) ? 1 : 0;
      evt    = (strobe == 1 && m_prev == 0) ? 1 : 0;
      m_prev = strobe;
      base   = op_start ? 0 : m_tgl;
      m_tgl  = base;
      if (evt == 1) begin
        if (op_busy) begin
          m_data = (op_erase ? 0 : (prog_byte[7] ? 0 : 128)) + base * 64;
          m_tgl  = 1 - base;
          m_tag  = op_erase ? "R4/R5/R6" : "R3/R5/R6";
        end else begin
          m_data = array_rdata;
          m_tag  = "R7";
        end
      end else begin
        m_tag = "R8";
      end
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done)
      check(rd_data == m_data[7:0], m_tag, rd_data, m_data);
  end

  task automatic read_once(output logic [7:0] v);
    host_sel = 1; host_oe = 1;
    @(negedge clk); v = rd_data;
    host_sel = 0; host_oe = 0;
    @(negedge clk);
  endtask

  task automatic start_op(input bit erase, input logic [7:0] pb);
    op_start = 1; op_busy = 1; op_erase = erase; prog_byte = pb;
    @(negedge clk);
    op_start = 0;
  endtask

  initial begin
    logic [7:0] v;
    logic [7:0] seq [4];
    logic [15:0] lfsr;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(rd_data == 8'h00, "R1 reset value", rd_data, 0);

    // idle read returns array data
    array_rdata = 8'h5A;
    read_once(v);
    check(v == 8'h5A, "R7 idle read", v, 8'h5A);

    // program busy, back-to-back reads
    start_op(0, 8'h35);
    for (int i = 0; i < 4; i++) read_once(seq[i]);
    check(seq[0][6] == 0 && seq[1][6] == 1 && seq[2][6] == 0 && seq[3][6] == 1,
          "R5 toggle alternates", {seq[0][6], seq[1][6], seq[2][6], seq[3][6]}, 4'b0101);
    check(seq[0][7] == 1, "R3 poll inverted", seq[0][7], 1);
    check(seq[1][5:0] == 0, "R6 low bits zero", seq[1][5:0], 0);

    // held strobe counts as one access
    host_sel = 1; host_oe = 1;
    repeat (5) @(negedge clk);
    check(rd_data[6] == 0, "R2 held strobe one read", rd_data[6], 0);
    host_sel = 0; host_oe = 0;
    @(negedge clk);
    read_once(v);
    check(v[6] == 1, "R2 next read after hold", v[6], 1);

    // hold between accesses
    repeat (4) @(negedge clk);
    check(rd_data == v, "R8 output holds", rd_data, v);

    // completion: true data
    op_busy = 0; array_rdata = 8'h35;
    read_once(v);
    check(v == 8'h35, "R7 true data on completion", v, 8'h35);
    read_once(v);
    check(v == 8'h35, "R7 toggle stopped", v, 8'h35);

    // program with top bit set
    start_op(0, 8'hC3);
    read_once(v);
    check(v == 8'h00, "R3 poll for msb 1", v, 8'h00);

    // erase
    start_op(1, 8'hFF);
    read_once(v);
    check(v == 8'h00, "R4 erase first read", v, 8'h00);
    read_once(v);
    check(v == 8'h40, "R4 erase second read", v, 8'h40);

    // start coincident with read
    read_once(v);
    op_start = 1; host_sel = 1; host_oe = 1;
    @(negedge clk);
    op_start = 0; v = rd_data; host_sel = 0; host_oe = 0;
    check(v[6] == 0, "R9 read with start", v[6], 0);
    @(negedge clk);
    read_once(v);
    check(v[6] == 1, "R9 read after start", v[6], 1);

    // idle read mid-operation leaves toggle alone
    op_busy = 0; array_rdata = 8'hA7;
    read_once(v);
    check(v == 8'hA7, "R7 idle read mid-op", v, 8'hA7);
    op_busy = 1;
    read_once(v);
    check(v[6] == 0, "R7 toggle unchanged by idle read", v[6], 0);

    // pseudo-random phase checked by the model
    lfsr = 16'hACE1;
    for (int n = 0; n < 400; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      host_sel    = lfsr[0] | lfsr[3];
      host_oe     = lfsr[1] | lfsr[4];
      op_busy     = lfsr[2] | lfsr[7];
      op_erase    = lfsr[5];
      op_start    = (lfsr[11:8] == 4'h3);
      prog_byte   = lfsr[15:8];
      array_rdata = lfsr[7:0] ^ lfsr[15:8];
      @(negedge clk);
    end
    op_start = 0; host_sel = 0; host_oe = 0;
    @(negedge clk);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule